// File: doc/BRIEF.md
# Priority transmit line scanner

This block decides which of several serial transmit lines is offered to software next. A line is a candidate when software has enabled it and its serializer reports an empty holding buffer. While the master scan enable is high, the scanner searches the candidates. It takes the highest-numbered one, places that number in a small line field and raises transmitter-ready. If the transmit interrupt enable is also high, it requests an interrupt. The scanner then stays on that line until software answers. Software answers either by writing a character, which is steered to the latched line as a one-cycle load strobe, or by turning that line's enable off. After a fixed pause of `RESUME_GAP` cycles the search starts again.

The block also holds the control register. This register carries one enable bit per line in its low byte and one data-terminal-ready output per line in its high byte, and each byte can be written on its own. The state machine has four states:
- `ST_IDLE`: scanning is off.
- `ST_SCAN`: searching for a candidate.
- `ST_HOLD`: a line is offered and transmitter-ready is high.
- `ST_GAP`: the pause after service.

The transitions are:
- `ST_IDLE`→`ST_SCAN` when scan enable is high.
- `ST_SCAN`→`ST_HOLD` when a candidate exists.
- `ST_HOLD`→`ST_GAP` on a write or when the held line's enable reads 0.
- `ST_GAP`→`ST_HOLD` or `ST_GAP`→`ST_SCAN` when the pause ends, depending on whether a candidate exists.
- Any state→`ST_IDLE` on software clear or when scan enable goes low.

Top module: `tx_line_scanner`

## Requirements
- R1: While `rst_n` is low, `trdy`, `irq`, `tx_load`, `dtr` and `ctl_rdata` are all zero.
- R2: `ctl_rdata` shows the line enables in bits 3:0 and the terminal-ready bits in bits 11:8, with all other bits zero. A low-byte write loads the enables from `ctl_wdata[3:0]`. A high-byte write loads the terminal-ready bits from `ctl_wdata[11:8]`. Each byte write leaves the other field unchanged.
- R3: A `soft_clr` pulse clears all line enables and drops `trdy` at the next edge. It leaves the terminal-ready bits unchanged.
- R4: In `ST_SCAN` with scan enable high, if any line has its enable set and `tbuf_empty` high, `trdy` rises at the next edge. At that point `tline` holds the highest-numbered such line, so line 3 wins over line 0.
- R5: While `trdy` is high and unserviced, `tline` and `trdy` do not change, whatever happens on the other lines.
- R6: `tx_load` is one-hot at bit `tline` in the same cycle as a `tbuf_wr` while `trdy` is high. A `tbuf_wr` while `trdy` is low drives no `tx_load` bit.
- R7: `trdy` falls at the edge that samples `tbuf_wr`. It also falls at the first edge at which the held line's enable bit reads 0.
- R8: After `trdy` falls through service, it stays low for exactly `RESUME_GAP` edges. It is high after the next edge if a line is then eligible.
- R9: `irq` is high exactly when `trdy` and `tie` are both high.
- R10: With `mse` low, `trdy` is low after the next edge and no line is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus initialize, active low; clears everything |
| soft_clr | input | 1 | Software clear; clears enables and scanner, keeps terminal-ready |
| mse | input | 1 | Master scan enable |
| tie | input | 1 | Transmit interrupt enable |
| ctl_wr_lo | input | 1 | Write strobe for control register low byte |
| ctl_wr_hi | input | 1 | Write strobe for control register high byte |
| ctl_wdata | input | DW | Control register write data |
| ctl_rdata | output | DW | Control register read data |
| tbuf_empty | input | NLINES | Per-line holding buffer empty, from serializers |
| tbuf_wr | input | 1 | Character write to the transmit buffer |
| tx_load | output | NLINES | One-hot load strobe to the selected serializer |
| trdy | output | 1 | Transmitter ready |
| tline | output | LW | Number of the line being offered |
| irq | output | 1 | Transmit interrupt request |
| dtr | output | NLINES | Data-terminal-ready outputs |

## Verification
`trdy` and `tline` are registered, so they answer a stimulus one edge later: after a candidate appears in `ST_SCAN`, after a service write, or after scan enable drops. After service, the held line's re-offer takes `RESUME_GAP` edges. `tx_load` and `irq` are combinational and are due in the same cycle as `tbuf_wr` or `tie`. Register fields appear on `ctl_rdata` one edge after a byte write. The bench drives inputs just after the falling edge. It checks the combinational results one nanosecond later, then advances a bench-side model through the rising edge, so every registered result is compared against the model in the cycle that follows its edge.

// File: rtl/tls_pkg.sv
package tls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2,
        ST_GAP  = 2'd3
    } scan_state_t;
endpackage

// File: rtl/tls_ctl_reg.sv
module tls_ctl_reg #(
    parameter int NLINES  = 4,
    parameter int DW      = 16,
    parameter int EN_LSB  = 0,
    parameter int DTR_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DW-1:0]     wdata,
    output logic [NLINES-1:0] line_en,
    output logic [NLINES-1:0] dtr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_en <= '0;
        end else if (soft_clr) begin
            line_en <= '0;
        end else if (wr_lo) begin
            line_en <= wdata[EN_LSB +: NLINES];
        end
    end

    // terminal-ready survives the software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dtr <= '0;
        end else if (wr_hi) begin
            dtr <= wdata[DTR_LSB +: NLINES];
        end
    end

    // R2
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !soft_clr) |=> $stable(line_en));
    // R3
    dtr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(dtr));
    // R3
    clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (line_en == '0));
endmodule

// File: rtl/tls_prio.sv
module tls_prio #(
    parameter int NLINES = 4,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] mask,
    output logic              any,
    output logic [LW-1:0]     idx
);
    // ascending sweep: the last hit, i.e. the highest line, wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (mask[i]) begin
                any = 1'b1;
                idx = LW'(i);
            end
        end
    end
endmodule

// File: rtl/tx_line_scanner.sv
module tx_line_scanner
    import tls_pkg::*;
#(
    parameter int NLINES     = 4,
    parameter int RESUME_GAP = 2,
    parameter int DW         = 16,
    localparam int LW        = $clog2(NLINES),
    localparam int GCW       = $clog2(RESUME_GAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              mse,
    input  logic              tie,
    input  logic              ctl_wr_lo,
    input  logic              ctl_wr_hi,
    input  logic [DW-1:0]     ctl_wdata,
    output logic [DW-1:0]     ctl_rdata,
    input  logic [NLINES-1:0] tbuf_empty,
    input  logic              tbuf_wr,
    output logic [NLINES-1:0] tx_load,
    output logic              trdy,
    output logic [LW-1:0]     tline,
    output logic              irq,
    output logic [NLINES-1:0] dtr
);
    localparam int EN_LSB  = 0;
    localparam int DTR_LSB = 8;

    logic [NLINES-1:0] line_en;
    logic [NLINES-1:0] elig;
    logic              any;
    logic [LW-1:0]     pick;

    scan_state_t       state_q, state_d;
    logic [LW-1:0]     line_q, line_d;
    logic [GCW-1:0]    cnt_q, cnt_d;

    tls_ctl_reg #(
        .NLINES(NLINES), .DW(DW), .EN_LSB(EN_LSB), .DTR_LSB(DTR_LSB)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_lo(ctl_wr_lo), .wr_hi(ctl_wr_hi), .wdata(ctl_wdata),
        .line_en(line_en), .dtr(dtr)
    );

    assign elig = line_en & tbuf_empty;

    tls_prio #(.NLINES(NLINES), .LW(LW)) u_prio (
        .mask(elig), .any(any), .idx(pick)
    );

    // next-state process
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        cnt_d   = cnt_q;
        if (soft_clr || !mse) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_SCAN;
                ST_SCAN: begin
                    if (any) begin
                        state_d = ST_HOLD;
                        line_d  = pick;
                    end
                end
                ST_HOLD: begin
                    if (tbuf_wr || !line_en[line_q]) begin
                        state_d = ST_GAP;
                        cnt_d   = GCW'(RESUME_GAP - 1);
                    end
                end
                ST_GAP: begin
                    if (cnt_q == '0) begin
                        if (any) begin
                            state_d = ST_HOLD;
                            line_d  = pick;
                        end else begin
                            state_d = ST_SCAN;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        trdy  = (state_q == ST_HOLD);
        irq   = trdy && tie;
        tline = line_q;
        ctl_rdata = '0;
        ctl_rdata[EN_LSB  +: NLINES] = line_en;
        ctl_rdata[DTR_LSB +: NLINES] = dtr;
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_load
        assign tx_load[g] = trdy && tbuf_wr && (line_q == LW'(g));
    end

    // R4
    pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && mse && !soft_clr && any) |=> (trdy && tline == $past(pick)));
    // R4
    prio_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> elig[pick]);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && !tbuf_wr && line_en[tline] && mse && !soft_clr) |=> (trdy && $stable(tline)));
    // R6
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load != '0) |-> (trdy && tbuf_wr && $onehot0(tx_load)));
    // R7
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && tbuf_wr) |=> !trdy);
    // R8
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && cnt_q != '0) |=> !trdy);
    // R10
    mse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mse |=> !trdy);
endmodule

// File: tb/tx_line_scanner_test.sv
module tx_line_scanner_test;
    localparam int NL  = 4;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0, mse = 1'b0, tie = 1'b0;
    logic        wl = 1'b0, wh = 1'b0, tw = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic [3:0]  empty = 4'hF;
    logic [3:0]  load, dtr;
    logic        trdy, irq;
    logic [1:0]  tline;

    always #2 clk = ~clk;

    tx_line_scanner #(.NLINES(NL), .RESUME_GAP(GAP), .DW(16)) uut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .mse(mse), .tie(tie),
        .ctl_wr_lo(wl), .ctl_wr_hi(wh), .ctl_wdata(wd), .ctl_rdata(rdata),
        .tbuf_empty(empty), .tbuf_wr(tw), .tx_load(load),
        .trdy(trdy), .tline(tline), .irq(irq), .dtr(dtr)
    );

    int checks = 0;
    int errors = 0;
    // bench model: 0 idle, 1 scan, 2 hold, 3 gap
    int          m_st = 0, m_line = 0, m_cnt = 0;
    logic [3:0]  m_en = '0, m_dtr = '0;
    int          busy [4] = '{0, 0, 0, 0};
    int          busy_fix = 50;
    logic [3:0]  last_load = '0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int top_line(input logic [3:0] m);
        int r = -1;
        for (int i = 0; i < 4; i++) if (m[i]) r = i;
        return r;
    endfunction

    task automatic cyc(input logic [15:0] d, input logic l, input logic h,
                       input logic c, input logic ms, input logic ti, input logic w);
        logic       e_trdy;
        logic [3:0] e_load, el;
        int         n_st, n_line, n_cnt;
        wd = d; wl = l; wh = h; soft_clr = c; mse = ms; tie = ti; tw = w;
        for (int i = 0; i < 4; i++) empty[i] = (busy[i] == 0);
        #1;
        e_trdy = (m_st == 2);
        e_load = (e_trdy && w) ? 4'(1 << m_line) : 4'h0;
        chk("R4/R5/R7/R8/R10 trdy", 16'(trdy), 16'(e_trdy));
        if (e_trdy) chk("R4/R5 tline", 16'(tline), 16'(m_line));
        chk("R6 tx_load", 16'(load), 16'(e_load));
        chk("R9 irq", 16'(irq), 16'(e_trdy && ti));
        chk("R2 rdata", rdata, {4'h0, m_dtr, 4'h0, m_en});
        chk("R2/R3 dtr", 16'(dtr), 16'(m_dtr));
        last_load = load;
        el = m_en & empty;
        n_st = m_st; n_line = m_line; n_cnt = m_cnt;
        if (c || !ms) n_st = 0;
        else begin
            case (m_st)
                0: n_st = 1;
                1: if (el != 0) begin n_st = 2; n_line = top_line(el); end
                2: if (w || !m_en[m_line]) begin n_st = 3; n_cnt = GAP - 1; end
                default: begin
                    if (m_cnt == 0) begin
                        if (el != 0) begin n_st = 2; n_line = top_line(el); end
                        else n_st = 1;
                    end else n_cnt = m_cnt - 1;
                end
            endcase
        end
        @(posedge clk);
        m_st = n_st; m_line = n_line; m_cnt = n_cnt;
        if (c) m_en = 4'h0; else if (l) m_en = d[3:0];
        if (h) m_dtr = d[11:8];
        for (int i = 0; i < 4; i++) begin
            if (e_load[i]) busy[i] = (busy_fix != 0) ? busy_fix : 1 + int'($urandom % 8);
            else if (busy[i] > 0) busy[i]--;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tie = 1'b1; tw = 1'b1; wl = 1'b1; wh = 1'b1; wd = 16'hFFFF; mse = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 trdy", 16'(trdy), 16'h0);
            chk("R1 irq", 16'(irq), 16'h0);
            chk("R1 tx_load", 16'(load), 16'h0);
            chk("R1 rdata", rdata, 16'h0);
            chk("R1 dtr", 16'(dtr), 16'h0);
        end
        tie = 1'b0; tw = 1'b0; wl = 1'b0; wh = 1'b0; wd = '0; mse = 1'b0;
        rst_n = 1'b1;

        // directed corner cases
        cyc(16'h0A00, 0, 1, 0, 0, 0, 0);
        chk("R2 high byte only", rdata, 16'h0A00);
        cyc(16'h000F, 1, 0, 0, 1, 0, 0);
        chk("R2 low byte only", rdata, 16'h0A0F);
        cyc(16'h0000, 0, 0, 0, 1, 0, 0);
        chk("R4 ready after search", 16'(trdy), 16'h1);
        chk("R4 line 3 wins", 16'(tline), 16'h3);
        for (int i = 0; i < 4; i++) begin
            cyc(16'h0500, 0, 1, 0, 1, 0, 0);
            chk("R5 held", 16'({trdy, tline}), 16'h7);
        end
        cyc(16'h0000, 0, 0, 0, 1, 0, 1);
        chk("R6 load to line 3", 16'(last_load), 16'h8);
        chk("R8 low after service", 16'(trdy), 16'h0);
        cyc(16'h0000, 0, 0, 0, 1, 0, 0);
        chk("R8 still low in pause", 16'(trdy), 16'h0);
        cyc(16'h0000, 0, 0, 0, 1, 0, 0);
        chk("R8 re-offer after pause", 16'({trdy, tline}), 16'h6);
        cyc(16'h000B, 1, 0, 0, 1, 0, 0);
        cyc(16'h0000, 0, 0, 0, 1, 0, 0);
        chk("R7 enable cleared drops ready", 16'(trdy), 16'h0);
        cyc(16'h0000, 0, 0, 0, 1, 0, 0);
        cyc(16'h0000, 0, 0, 0, 1, 0, 0);
        chk("R8 next line offered", 16'({trdy, tline}), 16'h5);
        cyc(16'h0000, 0, 0, 0, 1, 1, 0);
        chk("R9 irq with tie", 16'(irq), 16'h1);
        cyc(16'h0000, 0, 0, 0, 0, 0, 0);
        chk("R10 scan off", 16'(trdy), 16'h0);
        cyc(16'h0000, 0, 0, 0, 0, 0, 1);
        chk("R6 write without ready", 16'(last_load), 16'h0);
        cyc(16'h0000, 0, 0, 1, 1, 0, 0);
        chk("R3 clear keeps dtr", rdata, 16'h0500);
        chk("R3 clear drops ready", 16'(trdy), 16'h0);

        // random phase
        busy_fix = 0;
        for (int n = 0; n < 4000; n++) begin
            logic l, h, c, ms, ti, w;
            l  = ($urandom % 8) == 0;
            h  = ($urandom % 16) == 0;
            c  = ($urandom % 64) == 0;
            ms = ($urandom % 16) != 0;
            ti = 1'($urandom);
            w  = (m_st == 2) ? (($urandom % 2) == 0) : (($urandom % 32) == 0);
            cyc(16'($urandom), l, h, c, ms, ti, w);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule